// File: doc/BRIEF.md
# Character Page Mapper with Mode-Selected Mask

This block turns a picture-unit pattern-table address into the number of a physical 1 KB page of character memory. The 8 KB pattern space is split into eight 1 KB slots. Each slot takes a bank byte from one of eight registers. A mode value sets how many low bits of that byte survive, and an outer base fills the bits above them. The base is built from bits of three separate registers. A swap control exchanges the lower and upper 4 KB halves. A final AND mask and OR value confine the result to the size of the attached memory.

A build-time variant selects the outer limits. The standard variant keeps 15 page bits. The constrained variant keeps 14 bits, adds an OR value taken from the program-side outer bank bits shifted up by three, and allows a bypass. When the bypass is active, every pattern access goes to a fixed 8 KB character RAM. The block also drives the nametable mirroring select. Register decoding and the memories themselves are outside this block. Outputs are registered once.

Top module: `chr_bank_map`

## Requirements
- R1: While `rst` is high at a clock edge, `page`, `ram_sel` and `mirror_h` become 0.
- R2: The low 3 bits of `mode_reg` give a shift of 0,1,2,0,3,4,5,0 for values 0..7. The bank mask is 0xFF shifted right by that amount.
- R3: The outer base is `outer_nib`×2048 + `grp_bits`×16 + (`mode_reg` AND NOT mask), added as integers.
- R4: The slot is address bits 12:10 (`ppu_addr_top[2:0]`). Slots 0,1,2,3 use `bank_a0`, `bank_a1`, `bank_b0`, `bank_b1`. Slots 4..7 use bytes 0..3 of `bank_quad`, where byte k is bits 8k+7:8k.
- R5: When `swap_halves` is 1, slot bit 2 is inverted before the bank is chosen, so the two 4 KB halves exchange.
- R6: `page` = ((base OR (bank AND mask)) AND A) OR B. The standard variant uses A = 0x7FFF and B = 0. The constrained variant uses A = 0x3FFF and B = `prg_or`×8.
- R7: In the constrained variant, with `ram_bypass` = 1 and address bit 13 = 0, `ram_sel` is 1. `page` is then address bits 12:10, with no swap applied.
- R8: `ram_sel` is 0 for addresses at or above 0x2000, and always 0 in the standard variant, whatever `ram_bypass` holds.
- R9: `mirror_h` is the inverse of `mirror_bit`.
- R10: All outputs follow their inputs with exactly one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ppu_addr_top | input | 4 | Pattern address bits 13:10 |
| outer_nib | input | 4 | Outermost base nibble |
| grp_bits | input | 3 | Middle base group bits |
| mode_reg | input | 8 | Mask mode (bits 2:0) and base fill bits |
| swap_halves | input | 1 | Exchange the 4 KB halves |
| bank_a0 | input | 8 | Bank for slot 0 |
| bank_a1 | input | 8 | Bank for slot 1 |
| bank_b0 | input | 8 | Bank for slot 2 |
| bank_b1 | input | 8 | Bank for slot 3 |
| bank_quad | input | 32 | Banks for slots 4..7 |
| prg_or | input | 13 | Program-side outer OR value |
| ram_bypass | input | 1 | Route patterns to the fixed RAM |
| mirror_bit | input | 1 | Mirror control bit |
| page | output | 16 | Physical 1 KB page number |
| ram_sel | output | 1 | 1 selects character RAM |
| mirror_h | output | 1 | Mirroring select |

## Verification
The bench runs every mask mode against all sixteen address slots, both swap settings and both bypass settings. It uses three distinct sets of bank, base and OR values. The distinct bank bytes show whether the slot-to-register wiring and the half exchange are correct. The varying base fields show whether the base is added or ORed, and whether the base bits leak through the mask. With all-ones banks and a zero base, a separate pass isolates the mask table. Running both variants side by side separates the two outer limits and shows the bypass acting in one variant and being ignored in the other.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  localparam int BANK_W = 8;
  localparam int PAGE_W = 16;
  localparam int SLOT_W = 3;
  localparam int NSLOT  = 1 << SLOT_W;

  // shift amount per mask mode
  function automatic logic [2:0] mode_shift(input logic [2:0] m);
    case (m)
      3'd1:    mode_shift = 3'd1;
      3'd2:    mode_shift = 3'd2;
      3'd4:    mode_shift = 3'd3;
      3'd5:    mode_shift = 3'd4;
      3'd6:    mode_shift = 3'd5;
      default: mode_shift = 3'd0;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] mode_mask(input logic [2:0] m);
    mode_mask = {BANK_W{1'b1}} >> mode_shift(m);
  endfunction

  function automatic logic [PAGE_W-1:0] outer_base(input logic [3:0] nib,
                                                   input logic [2:0] grp,
                                                   input logic [BANK_W-1:0] mreg,
                                                   input logic [BANK_W-1:0] msk);
    outer_base = (PAGE_W'(nib) << 11) + (PAGE_W'(grp) << 4)
               + PAGE_W'(mreg & ~msk);
  endfunction

  function automatic logic [PAGE_W-1:0] final_page(input logic [PAGE_W-1:0] base,
                                                   input logic [BANK_W-1:0] bank,
                                                   input logic [BANK_W-1:0] msk,
                                                   input logic [PAGE_W-1:0] and_m,
                                                   input logic [PAGE_W-1:0] or_v);
    final_page = ((base | PAGE_W'(bank & msk)) & and_m) | or_v;
  endfunction
endpackage

// File: rtl/chr_mask_gen.sv
module chr_mask_gen
  import chr_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        outer_nib,
  input  logic [2:0]        grp_bits,
  input  logic [BANK_W-1:0] mode_reg,
  output logic [BANK_W-1:0] mask,
  output logic [PAGE_W-1:0] base
);
  assign mask = mode_mask(mode_reg[2:0]);
  assign base = outer_base(outer_nib, grp_bits, mode_reg, mask);

  // R2: the mask is always a run of ones starting at bit 0
  a_r2_mask_contig: assert property (@(posedge clk) disable iff (rst)
    $onehot({1'b0, mask} + {1'b0, {(BANK_W-1){1'b0}}, 1'b1}));
  // R2: never narrower than three bits
  a_r2_mask_floor: assert property (@(posedge clk) disable iff (rst)
    mask[2:0] == 3'b111);
endmodule

// File: rtl/chr_slot_sel.sv
module chr_slot_sel
  import chr_map_pkg::*;
(
  input  logic [SLOT_W-1:0]       slot_raw,
  input  logic                    swap_halves,
  input  logic [BANK_W-1:0]       bank_a0,
  input  logic [BANK_W-1:0]       bank_a1,
  input  logic [BANK_W-1:0]       bank_b0,
  input  logic [BANK_W-1:0]       bank_b1,
  input  logic [4*BANK_W-1:0]     bank_quad,
  output logic [SLOT_W-1:0]       slot_eff,
  output logic [BANK_W-1:0]       bank_val
);
  logic [BANK_W-1:0] table_q [NSLOT];

  assign table_q[0] = bank_a0;
  assign table_q[1] = bank_a1;
  assign table_q[2] = bank_b0;
  assign table_q[3] = bank_b1;

  genvar k;
  generate
    for (k = 0; k < NSLOT/2; k++) begin : g_quad
      assign table_q[NSLOT/2 + k] = bank_quad[k*BANK_W +: BANK_W];
    end
  endgenerate

  assign slot_eff = slot_raw ^ {swap_halves, {(SLOT_W-1){1'b0}}};
  assign bank_val = table_q[slot_eff];
endmodule

// File: rtl/chr_bank_map.sv
module chr_bank_map
  import chr_map_pkg::*;
#(
  parameter int ALT_VARIANT = 1,
  parameter int PRG_OR_W    = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           ppu_addr_top,
  input  logic [3:0]           outer_nib,
  input  logic [2:0]           grp_bits,
  input  logic [BANK_W-1:0]    mode_reg,
  input  logic                 swap_halves,
  input  logic [BANK_W-1:0]    bank_a0,
  input  logic [BANK_W-1:0]    bank_a1,
  input  logic [BANK_W-1:0]    bank_b0,
  input  logic [BANK_W-1:0]    bank_b1,
  input  logic [4*BANK_W-1:0]  bank_quad,
  input  logic [PRG_OR_W-1:0]  prg_or,
  input  logic                 ram_bypass,
  input  logic                 mirror_bit,
  output logic [PAGE_W-1:0]    page,
  output logic                 ram_sel,
  output logic                 mirror_h
);
  localparam int OR_SHIFT = 3;
  localparam logic [PAGE_W-1:0] AND_STD = 16'h7FFF;
  localparam logic [PAGE_W-1:0] AND_ALT = 16'h3FFF;

  logic [BANK_W-1:0] mask;
  logic [PAGE_W-1:0] base;
  logic [SLOT_W-1:0] slot_raw, slot_eff;
  logic [BANK_W-1:0] bank_val;
  logic [PAGE_W-1:0] and_m, or_v;
  logic              ram_hit;
  logic [PAGE_W-1:0] banked_page, page_d;

  assign slot_raw = ppu_addr_top[SLOT_W-1:0];

  chr_mask_gen u_mask (
    .clk(clk), .rst(rst), .outer_nib(outer_nib), .grp_bits(grp_bits),
    .mode_reg(mode_reg), .mask(mask), .base(base)
  );

  chr_slot_sel u_slot (
    .slot_raw(slot_raw), .swap_halves(swap_halves),
    .bank_a0(bank_a0), .bank_a1(bank_a1), .bank_b0(bank_b0), .bank_b1(bank_b1),
    .bank_quad(bank_quad), .slot_eff(slot_eff), .bank_val(bank_val)
  );

  generate
    if (ALT_VARIANT != 0) begin : g_alt
      assign and_m   = AND_ALT;
      assign or_v    = PAGE_W'({prg_or, {OR_SHIFT{1'b0}}});
      assign ram_hit = ram_bypass & ~ppu_addr_top[3];
    end else begin : g_std
      logic unused_std;
      assign unused_std = ^{prg_or, ram_bypass};
      assign and_m   = AND_STD;
      assign or_v    = '0;
      assign ram_hit = 1'b0;
    end
  endgenerate

  assign banked_page = final_page(base, bank_val, mask, and_m, or_v);
  assign page_d      = ram_hit ? PAGE_W'(slot_raw) : banked_page;

  always_ff @(posedge clk) begin
    if (rst) begin
      page     <= '0;
      ram_sel  <= 1'b0;
      mirror_h <= 1'b0;
    end else begin
      page     <= page_d;
      ram_sel  <= ram_hit;
      mirror_h <= ~mirror_bit;
    end
  end

  // R7: a RAM page never leaves the 8 KB region
  a_r7_ram_page_small: assert property (@(posedge clk) disable iff (rst)
    ram_sel |-> (page[PAGE_W-1:SLOT_W] == '0));
  // R8: RAM is only selected for an address below 0x2000
  a_r8_ram_low_addr: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ram_sel) |-> !$past(ppu_addr_top[3]));
  // R9: mirroring output is the inverted control one clock later
  a_r9_mirror_inv: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mirror_h == !$past(mirror_bit)));
  generate
    if (ALT_VARIANT != 0) begin : g_alt_chk
      // R6: the top two page bits come only from the OR value
      a_r6_top_from_or: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ram_sel) |-> (page[PAGE_W-1 -: 2] == $past(prg_or[PRG_OR_W-1 -: 2])));
    end else begin : g_std_chk
      // R6, R8: standard variant clears bit 15 and never picks RAM
      a_r6_top_clear: assert property (@(posedge clk) disable iff (rst)
        !page[PAGE_W-1] && !ram_sel);
    end
  endgenerate
endmodule

// File: tb/chr_bank_map_tb.sv
`timescale 1ns/1ps
module chr_bank_map_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ppu_addr_top = '0;
  logic [3:0]  outer_nib = '0;
  logic [2:0]  grp_bits = '0;
  logic [7:0]  mode_reg = '0;
  logic        swap_halves = 1'b0;
  logic [7:0]  bank_a0 = '0, bank_a1 = '0, bank_b0 = '0, bank_b1 = '0;
  logic [31:0] bank_quad = '0;
  logic [12:0] prg_or = '0;
  logic        ram_bypass = 1'b0;
  logic        mirror_bit = 1'b0;
  logic [15:0] page_a, page_s;
  logic        rsel_a, rsel_s, mir_a, mir_s;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  chr_bank_map #(.ALT_VARIANT(1)) u_dut (
    .clk(clk), .rst(rst), .ppu_addr_top(ppu_addr_top), .outer_nib(outer_nib),
    .grp_bits(grp_bits), .mode_reg(mode_reg), .swap_halves(swap_halves),
    .bank_a0(bank_a0), .bank_a1(bank_a1), .bank_b0(bank_b0), .bank_b1(bank_b1),
    .bank_quad(bank_quad), .prg_or(prg_or), .ram_bypass(ram_bypass),
    .mirror_bit(mirror_bit), .page(page_a), .ram_sel(rsel_a), .mirror_h(mir_a)
  );

  chr_bank_map #(.ALT_VARIANT(0)) u_dut_std (
    .clk(clk), .rst(rst), .ppu_addr_top(ppu_addr_top), .outer_nib(outer_nib),
    .grp_bits(grp_bits), .mode_reg(mode_reg), .swap_halves(swap_halves),
    .bank_a0(bank_a0), .bank_a1(bank_a1), .bank_b0(bank_b0), .bank_b1(bank_b1),
    .bank_quad(bank_quad), .prg_or(prg_or), .ram_bypass(ram_bypass),
    .mirror_bit(mirror_bit), .page(page_s), .ram_sel(rsel_s), .mirror_h(mir_s)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mask(input logic [2:0] m);
    int w;
    if (m == 0 || m == 3 || m == 7) w = 8;
    else if (m < 3) w = 8 - int'(m);
    else w = 9 - int'(m);
    return 8'((16'd1 << w) - 16'd1);
  endfunction

  function automatic logic [7:0] bank_of(input int s);
    case (s)
      0: return bank_a0;
      1: return bank_a1;
      2: return bank_b0;
      3: return bank_b1;
      default: return bank_quad[(s-4)*8 +: 8];
    endcase
  endfunction

  function automatic logic [15:0] exp_page(input bit alt, input int s);
    int slot, base, pg;
    logic [7:0] m;
    m = exp_mask(mode_reg[2:0]);
    slot = s ^ (swap_halves ? 4 : 0);
    base = int'(outer_nib) * 2048 + int'(grp_bits) * 16 + int'(mode_reg & ~m);
    pg = base | int'(bank_of(slot) & m);
    if (alt) pg = (pg & 'h3FFF) | (int'(prg_or) * 8);
    else     pg = pg & 'h7FFF;
    return 16'(pg);
  endfunction

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] hold;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 page", page_a, 16'h0);
    check("R1 ram_sel", {15'b0, rsel_a}, 16'h0);
    check("R1 mirror", {15'b0, mir_a}, 16'h0);
    rst = 1'b0;

    // R2: mask isolated with all-ones banks and zero base
    bank_a0 = 8'hFF; bank_a1 = 8'hFF; bank_b0 = 8'hFF; bank_b1 = 8'hFF;
    bank_quad = 32'hFFFF_FFFF;
    for (int m = 0; m < 8; m++) begin
      mode_reg = 8'(m) & 8'h07;
      @(posedge clk); #1;
      check("R2 mask std", page_s, {8'h0, exp_mask(3'(m))} | (16'(m) & 16'h7 & ~{8'h0, exp_mask(3'(m))}));
    end

    // R4 R5 R6 R7 R8 R9: full sweep
    for (int p = 0; p < 3; p++) begin
      bank_a0 = 8'(8'h1D + p * 8'h35);
      bank_a1 = 8'(8'h62 + p * 8'h35);
      bank_b0 = 8'(8'hA7 + p * 8'h35);
      bank_b1 = 8'(8'hE9 + p * 8'h35);
      bank_quad = {8'(8'h4C + p * 8'h11), 8'(8'h93 + p * 8'h11),
                   8'(8'hD5 + p * 8'h11), 8'(8'h38 + p * 8'h11)};
      outer_nib = 4'(p * 5 + 3);
      grp_bits  = 3'(p * 3 + 2);
      prg_or    = 13'(p * 13'h0A03 + 13'h0800);
      for (int m = 0; m < 8; m++)
        for (int sw = 0; sw < 2; sw++)
          for (int by = 0; by < 2; by++)
            for (int a = 0; a < 16; a++) begin
              mode_reg    = {5'(p * 9 + m), 3'(m)};
              swap_halves = sw[0];
              ram_bypass  = by[0];
              ppu_addr_top = 4'(a);
              mirror_bit  = a[0] ^ p[0];
              @(posedge clk); #1;
              if (by == 1 && a < 8) begin
                check("R7 alt ram page", page_a, 16'(a));
                check("R7 alt ram_sel", {15'b0, rsel_a}, 16'h1);
              end else begin
                check("R4 R5 R6 alt page", page_a, exp_page(1'b1, a & 7));
                check("R8 alt ram_sel", {15'b0, rsel_a}, 16'h0);
              end
              check("R3 R6 std page", page_s, exp_page(1'b0, a & 7));
              check("R8 std ram_sel", {15'b0, rsel_s}, 16'h0);
              check("R9 mirror", {15'b0, mir_a}, {15'b0, ~mirror_bit});
            end
    end

    // R10: output holds until the next edge, then moves
    ram_bypass = 1'b0; swap_halves = 1'b0; ppu_addr_top = 4'd1;
    @(posedge clk); #1;
    hold = page_s;
    ppu_addr_top = 4'd6;
    #1;
    check("R10 hold before edge", page_s, hold);
    @(posedge clk); #1;
    check("R10 update after edge", page_s, exp_page(1'b0, 6));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule